// File: doc/BRIEF.md
# Boot-Time ROM Overlay Controller

This block decodes memory chip selects for an 8-bit processor with a 16-bit address bus. That processor starts fetching at address zero after reset. In normal operation the bottom of memory has to be RAM, because the operating system keeps live data there, and the non-maskable interrupt entry point at 0x0066 also sits in that area. The controller gets the processor to its boot code without tying ROM to address zero for good.

A strap input is sampled while reset is held and picks one of two boot schemes. In **slide** mode, every memory read below the high ROM window is answered with the all-zero no-operation opcode, and neither memory is selected. The program counter then steps through low memory until it reaches the ROM window. The first read inside that window ends slide mode until the next reset. In **overlay** mode, ROM shadows the low 8 KiB for reads and writes go to the RAM underneath. Software removes the overlay by writing to an I/O port. After boot, addresses in the ROM window select ROM and every other address selects RAM.

The processor core, the memories and the bus drivers are outside the block. The data-override outputs are meant to steer a multiplexer in front of the processor's data input.

Top module: `boot_rom_overlay`

## Requirements
- R1: In slide mode after reset, a memory read below the ROM window (default 0xE000) asserts the override enable with override value 0x00, and neither chip select is asserted.
- R2: In slide mode, a memory write below the ROM window asserts neither chip select nor the override.
- R3: In slide mode, a memory read inside the ROM window selects ROM. From the following cycle the block uses the normal decode and stays there until reset.
- R4: In overlay mode after reset, reads in 0x0000–0x1FFF select ROM and writes in that range select RAM.
- R5: An I/O write whose low 8 address bits equal 0x38 and whose data has bit 0 set removes the overlay from the next cycle. The upper address bits are ignored. A write with bit 0 clear, or a write to any other port, leaves the overlay in place.
- R6: Once removed, the overlay stays removed until reset, whatever further port writes occur.
- R7: Normal decode: addresses in the ROM window select ROM and all others select RAM. A read at 0x0066 therefore selects RAM.
- R8: The mode is taken from `boot_mode_i` while reset is asserted (0 = slide, 1 = overlay). Changes to it after reset have no effect.
- R9: Without a memory request, no chip select and no override is asserted. ROM and RAM selects are never asserted together.
- R10: Asserting reset restores the boot condition of the sampled mode, even after boot has finished.
- R11: The override is asserted only for reads and only in slide mode. In all other cases the override value output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_mode_i | input | 1 | Boot scheme strap, sampled in reset: 0 slide, 1 overlay |
| addr_i | input | 16 | Processor address bus |
| mem_req_i | input | 1 | Memory request strobe |
| rd_i | input | 1 | Read strobe (1 read, 0 write) |
| iowr_i | input | 1 | I/O write strobe |
| io_data_i | input | 8 | Data bus value during an I/O write |
| rom_cs_o | output | 1 | ROM chip select |
| ram_cs_o | output | 1 | RAM chip select |
| ovr_en_o | output | 1 | Drive the override value onto the processor data input |
| ovr_data_o | output | 8 | Override value (no-op opcode) |

## Verification
On every cycle the embedded assertions check the following: chip selects are mutually exclusive; the block stays quiet when no memory request is present; the override appears only on reads; the ROM window always selects ROM; both boot flags are sticky; a window read ends slide mode; and a matching port write removes the overlay. Several behaviours depend on the order of events and can only be shown by the bench's scenarios. These are the full-address sweeps in each boot phase, the port writes that must be ignored, a strap change after reset, and a reset issued after boot has finished.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

   typedef enum logic {
      BOOT_SLIDE   = 1'b0,
      BOOT_OVERLAY = 1'b1
   } boot_mode_e;

   typedef struct packed {
      logic rom_cs;
      logic ram_cs;
      logic ovr_en;
   } sel_t;

endpackage

// File: rtl/boot_addr_decode.sv
module boot_addr_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned ROM_BASE = 32'hE000,
   parameter int unsigned OVL_TOP  = 32'h1FFF
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              in_rom_o,
   output logic              in_ovl_o
);

   localparam int unsigned SPACE     = 32'd1 << ADDR_W;
   localparam int unsigned WIN_SIZE  = SPACE - ROM_BASE;
   localparam int unsigned OVL_SIZE  = OVL_TOP + 1;
   localparam bit          WIN_POW2  = (WIN_SIZE & (WIN_SIZE - 1)) == 0;
   localparam bit          OVL_POW2  = (OVL_SIZE & (OVL_SIZE - 1)) == 0;
   localparam int unsigned WIN_BITS  = $clog2(WIN_SIZE);
   localparam int unsigned OVL_BITS  = $clog2(OVL_SIZE);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(ROM_BASE);
   localparam logic [ADDR_W-1:0] TOP_V  = ADDR_W'(OVL_TOP);

   if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_width
      $error("boot_addr_decode: ADDR_W out of range");
   end
   if (ROM_BASE == 0 || ROM_BASE >= SPACE) begin : g_bad_base
      $error("boot_addr_decode: ROM_BASE must lie inside the address space above zero");
   end
   if (OVL_TOP >= ROM_BASE) begin : g_bad_ovl
      $error("boot_addr_decode: overlay range must end below the ROM window");
   end

   // ROM window: a power-of-two window at the top reduces to an all-ones test
   if (WIN_POW2 && WIN_BITS < ADDR_W) begin : g_win_mask
      assign in_rom_o = &addr_i[ADDR_W-1:WIN_BITS];
   end else begin : g_win_cmp
      assign in_rom_o = (addr_i >= BASE_V);
   end

   // Overlay range: a power-of-two range at the bottom reduces to an all-zeros test
   if (OVL_POW2 && OVL_BITS < ADDR_W) begin : g_ovl_mask
      assign in_ovl_o = ~|addr_i[ADDR_W-1:OVL_BITS];
   end else begin : g_ovl_cmp
      assign in_ovl_o = (addr_i <= TOP_V);
   end

endmodule

// File: rtl/boot_io_port.sv
module boot_io_port #(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PORT_ADDR   = 32'h38,
   parameter int unsigned UNMAP_MASK  = 32'h01
) (
   input  logic              iowr_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              unmap_o
);

   localparam logic [PORT_W-1:0] PORT_V = PORT_W'(PORT_ADDR);
   localparam logic [DATA_W-1:0] MASK_V = DATA_W'(UNMAP_MASK);

   if (PORT_ADDR >= (32'd1 << PORT_W)) begin : g_bad_port
      $error("boot_io_port: PORT_ADDR does not fit PORT_W");
   end
   if (UNMAP_MASK == 0 || UNMAP_MASK >= (32'd1 << DATA_W)) begin : g_bad_mask
      $error("boot_io_port: UNMAP_MASK must be a non-zero DATA_W value");
   end

   logic port_hit;
   logic data_hit;

   assign port_hit = (port_i == PORT_V);
   assign data_hit = ((data_i & MASK_V) == MASK_V);
   assign unmap_o  = iowr_i & port_hit & data_hit;

endmodule

// File: rtl/boot_flags.sv
module boot_flags
   import boot_ovl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic boot_mode_i,
   input  logic win_read_i,
   input  logic unmap_i,
   output logic slide_o,
   output logic ovl_o
);

   boot_mode_e strap;
   logic       slide_q;
   logic       ovl_q;

   assign strap = boot_mode_e'(boot_mode_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slide_q <= (strap == BOOT_SLIDE);
         ovl_q   <= (strap == BOOT_OVERLAY);
      end else begin
         if (win_read_i) slide_q <= 1'b0;
         if (unmap_i)    ovl_q   <= 1'b0;
      end
   end

   assign slide_o = slide_q;
   assign ovl_o   = ovl_q;

   a_r3_slide_ends: assert property (@(posedge clk) disable iff (!rst_n)
      slide_q && win_read_i |=> !slide_q);
   a_r3_slide_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !slide_q |=> !slide_q);
   a_r5_unmap: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_q && unmap_i |=> !ovl_q);
   a_r6_ovl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_q |=> !ovl_q);
   a_r8_one_scheme: assert property (@(posedge clk) disable iff (!rst_n)
      !(slide_q && ovl_q));

endmodule

// File: rtl/boot_select.sv
module boot_select
   import boot_ovl_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NOP_CODE = 32'h00
) (
   input  logic              mem_req_i,
   input  logic              rd_i,
   input  logic              in_rom_i,
   input  logic              in_ovl_i,
   input  logic              slide_i,
   input  logic              ovl_i,
   output sel_t              sel_o,
   output logic [DATA_W-1:0] ovr_data_o
);

   localparam logic [DATA_W-1:0] NOP_V = DATA_W'(NOP_CODE);

   if (NOP_CODE >= (32'd1 << DATA_W)) begin : g_bad_nop
      $error("boot_select: NOP_CODE does not fit DATA_W");
   end

   always_comb begin
      sel_o = '0;
      if (mem_req_i) begin
         if (slide_i && !in_rom_i) begin
            sel_o.ovr_en = rd_i;
         end else if (ovl_i && in_ovl_i) begin
            sel_o.rom_cs = rd_i;
            sel_o.ram_cs = !rd_i;
         end else begin
            sel_o.rom_cs = in_rom_i;
            sel_o.ram_cs = !in_rom_i;
         end
      end
   end

   assign ovr_data_o = sel_o.ovr_en ? NOP_V : '0;

endmodule

// File: rtl/boot_rom_overlay.sv
module boot_rom_overlay
   import boot_ovl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PORT_W     = 8,
   parameter int unsigned ROM_BASE   = 32'hE000,
   parameter int unsigned OVL_TOP    = 32'h1FFF,
   parameter int unsigned PORT_ADDR  = 32'h38,
   parameter int unsigned UNMAP_MASK = 32'h01,
   parameter int unsigned NOP_CODE   = 32'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              mem_req_i,
   input  logic              rd_i,
   input  logic              iowr_i,
   input  logic [DATA_W-1:0] io_data_i,
   output logic              rom_cs_o,
   output logic              ram_cs_o,
   output logic              ovr_en_o,
   output logic [DATA_W-1:0] ovr_data_o
);

   if (PORT_W > ADDR_W) begin : g_bad_port_w
      $error("boot_rom_overlay: PORT_W wider than ADDR_W");
   end

   logic in_rom;
   logic in_ovl;
   logic unmap;
   logic win_read;
   logic slide;
   logic ovl;
   sel_t sel;

   boot_addr_decode #(
      .ADDR_W   (ADDR_W),
      .ROM_BASE (ROM_BASE),
      .OVL_TOP  (OVL_TOP)
   ) u_dec (
      .addr_i   (addr_i),
      .in_rom_o (in_rom),
      .in_ovl_o (in_ovl)
   );

   boot_io_port #(
      .PORT_W     (PORT_W),
      .DATA_W     (DATA_W),
      .PORT_ADDR  (PORT_ADDR),
      .UNMAP_MASK (UNMAP_MASK)
   ) u_port (
      .iowr_i  (iowr_i),
      .port_i  (addr_i[PORT_W-1:0]),
      .data_i  (io_data_i),
      .unmap_o (unmap)
   );

   assign win_read = mem_req_i & rd_i & in_rom;

   boot_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_mode_i (boot_mode_i),
      .win_read_i  (win_read),
      .unmap_i     (unmap),
      .slide_o     (slide),
      .ovl_o       (ovl)
   );

   boot_select #(
      .DATA_W   (DATA_W),
      .NOP_CODE (NOP_CODE)
   ) u_sel (
      .mem_req_i  (mem_req_i),
      .rd_i       (rd_i),
      .in_rom_i   (in_rom),
      .in_ovl_i   (in_ovl),
      .slide_i    (slide),
      .ovl_i      (ovl),
      .sel_o      (sel),
      .ovr_data_o (ovr_data_o)
   );

   assign rom_cs_o = sel.rom_cs;
   assign ram_cs_o = sel.ram_cs;
   assign ovr_en_o = sel.ovr_en;

   a_r9_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_cs_o && ram_cs_o));
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req_i |-> !rom_cs_o && !ram_cs_o && !ovr_en_o);
   a_r11_ovr_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en_o |-> rd_i && slide && !rom_cs_o && !ram_cs_o);
   a_r7_window_rom: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_i && in_rom |-> rom_cs_o);

endmodule

// File: tb/boot_rom_overlay_test.sv
module boot_rom_overlay_test;

   localparam int ROM_BASE = 32'hE000;
   localparam int OVL_TOP  = 32'h1FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_mode_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic        mem_req_i = 1'b0;
   logic        rd_i = 1'b0;
   logic        iowr_i = 1'b0;
   logic [7:0]  io_data_i = '0;
   logic        rom_cs_o, ram_cs_o, ovr_en_o;
   logic [7:0]  ovr_data_o;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench model of the boot state
   bit m_slide;
   bit m_ovl;

   always #4 clk = ~clk;

   boot_rom_overlay uut (
      .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode_i),
      .addr_i(addr_i), .mem_req_i(mem_req_i), .rd_i(rd_i),
      .iowr_i(iowr_i), .io_data_i(io_data_i),
      .rom_cs_o(rom_cs_o), .ram_cs_o(ram_cs_o),
      .ovr_en_o(ovr_en_o), .ovr_data_o(ovr_data_o)
   );

   function automatic logic [10:0] expect_out(input int a, input bit req, input bit rd);
      bit win = (a >= ROM_BASE);
      bit low = (a <= OVL_TOP);
      if (!req)                 return 11'h000;
      if (m_slide && !win)      return rd ? {1'b0, 1'b0, 1'b1, 8'h00} : 11'h000;
      if (m_ovl && low)         return {rd, !rd, 1'b0, 8'h00};
      return {win, !win, 1'b0, 8'h00};
   endfunction

   task automatic apply(input string req_tag, input int a, input bit req, input bit rd,
                        input bit iow, input logic [7:0] d);
      logic [10:0] got, exp;
      @(negedge clk);
      addr_i = 16'(a); mem_req_i = req; rd_i = rd; iowr_i = iow; io_data_i = d;
      #1;
      exp = expect_out(a, req, rd);
      got = {rom_cs_o, ram_cs_o, ovr_en_o, ovr_data_o};
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s addr=%h req=%0b rd=%0b actual=%h expected=%h",
                  req_tag, a[15:0], req, rd, got, exp);
      end
      if (m_slide && req && rd && a >= ROM_BASE) m_slide = 1'b0;
      if (iow && a[7:0] == 8'h38 && d[0]) m_ovl = 1'b0;
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n = 1'b0; boot_mode_i = mode;
      mem_req_i = 1'b0; iowr_i = 1'b0; rd_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_slide = !mode;
      m_ovl = mode;
   endtask

   initial begin
      // slide mode
      do_reset(1'b0);
      apply("R9", 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00);
      apply("R1", 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00);
      for (int a = 1; a < ROM_BASE; a += 7) apply("R1", a, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R1", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R1", ROM_BASE - 1, 1'b1, 1'b1, 1'b0, 8'h00);
      for (int a = 0; a < ROM_BASE; a += 97) apply("R2", a, 1'b1, 1'b0, 1'b0, 8'h00);
      apply("R11", 16'h1000, 1'b1, 1'b1, 1'b1, 8'h01);   // port write ignored in slide mode
      apply("R9", 16'h0100, 1'b0, 1'b1, 1'b0, 8'h00);
      apply("R3", ROM_BASE, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R3", 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R7", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      for (int a = 0; a < 65536; a += 13) apply("R7", a, 1'b1, a[0], 1'b0, 8'h00);
      apply("R3", 16'h0005, 1'b1, 1'b1, 1'b0, 8'h00);

      // overlay mode
      do_reset(1'b1);
      apply("R9", 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00);
      for (int a = 0; a <= OVL_TOP; a += 5) apply("R4", a, 1'b1, 1'b1, 1'b0, 8'h00);
      for (int a = 0; a <= OVL_TOP; a += 11) apply("R4", a, 1'b1, 1'b0, 1'b0, 8'h00);
      apply("R4", OVL_TOP + 1, 1'b1, 1'b1, 1'b0, 8'h00);
      for (int a = OVL_TOP + 1; a < 65536; a += 17) apply("R7", a, 1'b1, 1'b1, 1'b0, 8'h00);
      boot_mode_i = 1'b0;                                 // strap change after reset
      apply("R8", 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R5", 16'h0038, 1'b0, 1'b0, 1'b1, 8'hFE);     // bit 0 clear
      apply("R5", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R5", 16'h0039, 1'b0, 1'b0, 1'b1, 8'h01);     // wrong port
      apply("R5", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R5", 16'h0038, 1'b0, 1'b0, 1'b0, 8'h01);     // no strobe
      apply("R5", 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R5", 16'hA538, 1'b0, 1'b0, 1'b1, 8'h81);     // upper bits ignored
      apply("R5", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R6", 16'h0038, 1'b0, 1'b0, 1'b1, 8'h00);
      for (int a = 0; a < 65536; a += 19) apply("R6", a, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R11", 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00);

      // reset after boot, strap in slide then overlay
      do_reset(1'b0);
      apply("R10", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R10", ROM_BASE + 3, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R10", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      do_reset(1'b1);
      apply("R10", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      apply("R10", 16'h0066, 1'b1, 1'b0, 1'b0, 8'h00);
      apply("R10", 16'h0038, 1'b0, 1'b0, 1'b1, 8'h01);
      apply("R10", 16'h0066, 1'b1, 1'b1, 1'b0, 8'h00);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule